// File: doc/BRIEF.md
# Two-Channel Timer Input Capture Unit

This block watches external pins and records when a chosen transition arrives on each one. Every channel passes its pin through a two-flop synchronizer and a history flop. It then checks for the polarity that software selected. When that transition arrives, the channel copies the present value of an incoming free-running counter into a capture register that software can only read. It also raises a status flag and, if enabled, asserts an interrupt line.

After a capture the channel is locked. The captured value stays frozen and further edges are dropped, not queued, until software reads the capture register. The strobe of that read clears the flag on the clock edge that ends it. A halt input blocks every capture while it is high.

Software reaches the unit through a small register port: an address, a read strobe, a write strobe and byte-wide data. One control/status register holds the edge selects, the interrupt enables and the flags. Each channel has its own capture register. The counter itself, its prescaler and interrupt vectoring sit outside the block.

Top module: `icu_top`

## Requirements
- R1: After synchronous reset the control/status register (address 0) reads 0x00, both capture registers read 0x00 and both interrupt outputs are low.
- R2: Control/status bit i (i = 0,1) selects the active edge of channel i: 0 = rising, 1 = falling. A transition of the opposite polarity sets no flag and asserts no interrupt.
- R3: After an active transition on pin i, with the pin then held stable, the flag (control/status bit 4+i) becomes set on the third rising clock edge that follows the transition. Capture register i (address 1+i) then holds the value cnt_i had at that edge.
- R4: Two rising clock edges after the transition, the flag of that channel is still clear.
- R5: Interrupt output i is high exactly while flag i and enable bit 2+i of the control/status register are both set. Setting the enable while the flag is already set raises the interrupt one cycle after the write.
- R6: While flag i is set, capture register i holds its value and further edges on pin i are ignored. After the flag is cleared, those edges do not produce a late capture.
- R7: A read strobe at address 1+i returns capture register i on rdata_o in the same cycle and clears flag i on the clock edge that ends the strobe.
- R8: While halt_i is high no flag is set and no capture register changes. Edges seen during halt are not replayed once halt falls.
- R9: A write to address 0 loads the edge selects from wdata bits 1:0 and the enables from bits 3:2. Writes to the flag bits, to the capture addresses and to address 3 change nothing. Address 3 reads 0x00.
- R10: When the counter advances only every N clocks (N = 1..4), the captured value is the counter value present at the capture edge, for every phase of the pin event within the counter period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Blocks all captures while high |
| cnt_i | input | 8 | Free-running counter value |
| pin_i | input | 2 | Capture input pins, one per channel |
| addr_i | input | 2 | Register address: 0 control/status, 1-2 capture registers |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 2 | Per-channel interrupt request |

## Verification
The bench sweeps counter prescale ratios of 1 to 4 against every phase of the pin event, on both channels and both polarities. It predicts each captured value from the tick count when the event happened. A design with an extra or missing synchronizer stage would store a value one count off, or would raise the flag two edges after the transition. The bench also sends a second edge into a locked channel and an edge during halt. A design that queued either edge would show a late flag after the read or after halt falls. A design that let a locked register reload would return the wrong count. Wrong-polarity transitions, writes to read-only bits and setting the enable while the flag is already set catch mixed-up decode and enable gating.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int NCH = 2;
    localparam int CW  = 8;
    localparam int AW  = 2;
    localparam int DW  = 8;

    // Control/status field positions
    localparam int SEL_LSB = 0;
    localparam int IE_LSB  = NCH;
    localparam int FLG_LSB = 2 * NCH;

    localparam logic [AW-1:0] CSR_ADDR = '0;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic meta;
        logic stable;
        logic hist;
    } sync_chain_t;

    function automatic logic [AW-1:0] cap_addr(input int ch);
        return AW'(ch + 1);
    endfunction

    function automatic logic edge_match(input edge_pol_e pol, input logic now, input logic prev);
        return (pol == EDGE_FALL) ? (prev & ~now) : (now & ~prev);
    endfunction

endpackage

// File: rtl/icu_edge_det.sv
module icu_edge_det
    import icu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  edge_pol_e pol_i,
    output logic      hit_o
);

    sync_chain_t chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q.meta   <= pin_i;
            chain_q.stable <= chain_q.meta;
            chain_q.hist   <= chain_q.stable;
        end
    end

    assign hit_o = edge_match(pol_i, chain_q.stable, chain_q.hist);

endmodule

// File: rtl/icu_chan.sv
module icu_chan
    import icu_pkg::*;
#(
    parameter int CNT_W = CW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             halt_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             flag_o,
    output logic [CNT_W-1:0] cap_o
);

    logic             flag_q;
    logic [CNT_W-1:0] cap_q;
    logic             take;

    // capture only when unlocked, not halted and not being released this cycle
    assign take = hit_i && !flag_q && !halt_i && !clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            if (clr_i) begin
                flag_q <= 1'b0;
            end else if (take) begin
                flag_q <= 1'b1;
            end
            if (take) begin
                cap_q <= cnt_i;
            end
        end
    end

    assign flag_o = flag_q;
    assign cap_o  = cap_q;

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> (flag_q && $stable(cap_q)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> ($stable(cap_q) && !$rose(flag_q)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !flag_q);

    // R3
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(hit_i));

endmodule

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int N_CH   = NCH,
    parameter int CNT_W  = CW,
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_CH-1:0]   flags_i,
    input  logic [CNT_W-1:0]  caps_i [N_CH],
    output logic [N_CH-1:0]   sel_o,
    output logic [N_CH-1:0]   ie_o,
    output logic [N_CH-1:0]   clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [N_CH-1:0] sel_q;
    logic [N_CH-1:0] ie_q;
    logic            csr_wr;

    assign csr_wr = wr_i && (addr_i == ADDR_W'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            ie_q  <= '0;
        end else if (csr_wr) begin
            sel_q <= wdata_i[SEL_LSB +: N_CH];
            ie_q  <= wdata_i[IE_LSB +: N_CH];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(0)) begin
            rdata_o[SEL_LSB +: N_CH] = sel_q;
            rdata_o[IE_LSB +: N_CH]  = ie_q;
            rdata_o[FLG_LSB +: N_CH] = flags_i;
        end
        for (int c = 0; c < N_CH; c++) begin
            if (addr_i == cap_addr(c)) begin
                rdata_o = DATA_W'(caps_i[c]);
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_clr
        assign clr_o[g] = rd_i && (addr_i == cap_addr(g));
    end

    assign sel_o = sel_q;
    assign ie_o  = ie_q;

    // R9
    csr_load_chk: assert property (@(posedge clk) disable iff (rst)
        csr_wr |=> (sel_q == $past(wdata_i[SEL_LSB +: N_CH]) && ie_q == $past(wdata_i[IE_LSB +: N_CH])));

    // R9
    csr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_wr |=> ($stable(sel_q) && $stable(ie_q)));

endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          halt_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [NCH-1:0] pin_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [NCH-1:0] irq_o
);

    logic [NCH-1:0] sel;
    logic [NCH-1:0] ie;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] flag;
    logic [CW-1:0]  cap [NCH];

    icu_regs #(
        .N_CH  (NCH),
        .CNT_W (CW),
        .ADDR_W(AW),
        .DATA_W(DW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr_i),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .wdata_i(wdata_i),
        .flags_i(flag),
        .caps_i (cap),
        .sel_o  (sel),
        .ie_o   (ie),
        .clr_o  (clr),
        .rdata_o(rdata_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        icu_edge_det u_edge (
            .clk  (clk),
            .rst  (rst),
            .pin_i(pin_i[g]),
            .pol_i(edge_pol_e'(sel[g])),
            .hit_o(hit[g])
        );

        icu_chan #(.CNT_W(CW)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .hit_i (hit[g]),
            .halt_i(halt_i),
            .clr_i (clr[g]),
            .cnt_i (cnt_i),
            .flag_o(flag[g]),
            .cap_o (cap[g])
        );

        assign irq_o[g] = flag[g] & ie[g];

        // R5
        irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !wr_i) |=> !irq_o[g]);
    end

endmodule

// File: tb/tb_icu_top.sv
`timescale 1ns/1ps
module tb_icu_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       halt;
    logic [7:0] cnt;
    logic [1:0] pin;
    logic [1:0] addr;
    logic       rd;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [1:0] irq;

    int nchk = 0;
    int nfail = 0;
    int tick = 0;
    int divv = 1;
    logic [7:0] last_cap [2];

    always #2.5 clk = ~clk;

    icu_top dut (
        .clk(clk), .rst(rst), .halt_i(halt), .cnt_i(cnt), .pin_i(pin),
        .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic step();
        @(negedge clk);
        tick++;
        cnt = 8'((tick / divv) % 256);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        step();
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #750000;
        nfail++;
        $display("FAIL watchdog actual=00 expected=01");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int t0;
        rst = 1'b1; halt = 1'b0; cnt = 8'h00; pin = 2'b00;
        addr = 2'd0; rd = 1'b0; wr = 1'b0; wdata = 8'h00;
        steps(4);
        rst = 1'b0;
        step();

        // R1 reset state
        #1 chk("R1 irq", {6'b0, irq}, 8'h00);
        rd_reg(2'd0, v); chk("R1 csr", v, 8'h00);
        rd_reg(2'd1, v); chk("R1 cap0", v, 8'h00);
        rd_reg(2'd2, v); chk("R1 cap1", v, 8'h00);

        // R10 / R3 / R4 / R2 sweep: prescale x phase x channel x polarity
        for (int d = 1; d <= 4; d++) begin
            for (int ph = 0; ph < d; ph++) begin
                for (int ch = 0; ch < 2; ch++) begin
                    for (int pol = 0; pol < 2; pol++) begin
                        divv = d;
                        wr_reg(2'd0, {4'b0, 2'b11, pol[0], pol[0]});
                        if (pin[ch] != pol[0]) begin
                            pin[ch] = pol[0];
                            steps(4);
                            #1 chk("R2 wrong edge ignored", {7'b0, irq[ch]}, 8'h00);
                        end
                        while ((tick + 1) % d != ph) step();
                        step();
                        t0 = tick;
                        pin[ch] = ~pin[ch];
                        steps(2);
                        #1 chk("R4 no flag after two edges", {7'b0, irq[ch]}, 8'h00);
                        step();
                        #1 chk("R3 flag after third edge", {7'b0, irq[ch]}, 8'h01);
                        rd_reg(2'd0, v);
                        chk("R3 csr flag bit", v & 8'h30, 8'(8'h10 << ch));
                        rd_reg(2'(ch + 1), v);
                        chk("R10 captured count", v, 8'(((t0 + 2) / d) % 256));
                        last_cap[ch] = v;
                        #1 chk("R7 irq cleared by read", {7'b0, irq[ch]}, 8'h00);
                        rd_reg(2'd0, v);
                        chk("R7 flags cleared", v & 8'h30, 8'h00);
                    end
                end
            end
        end

        // R5 enable gating and late enable
        divv = 1;
        wr_reg(2'd0, 8'h00);
        if (pin[0]) begin pin[0] = 1'b0; steps(4); end
        t0 = tick;
        pin[0] = 1'b1;
        steps(3);
        #1 chk("R5 irq masked", {6'b0, irq}, 8'h00);
        rd_reg(2'd0, v); chk("R5 flag set while masked", v, 8'h10);
        wr_reg(2'd0, 8'h04);
        #1 chk("R5 irq after late enable", {6'b0, irq}, 8'h01);

        // R6 lock: extra edges ignored, not queued
        pin[0] = 1'b0; steps(4);
        pin[0] = 1'b1; steps(4);
        rd_reg(2'd0, v); chk("R6 still one flag", v, 8'h14);
        rd_reg(2'd1, v); chk("R6 locked value", v, 8'(t0 + 2));
        last_cap[0] = v;
        steps(5);
        rd_reg(2'd0, v); chk("R6 no queued capture", v, 8'h04);

        // R8 halt blocks capture and is not replayed
        wr_reg(2'd0, 8'h08);
        if (pin[1]) begin pin[1] = 1'b0; steps(4); end
        halt = 1'b1;
        pin[1] = 1'b1;
        steps(5);
        #1 chk("R8 no irq under halt", {6'b0, irq}, 8'h00);
        halt = 1'b0;
        steps(4);
        rd_reg(2'd0, v); chk("R8 no replay after halt", v, 8'h08);
        rd_reg(2'd2, v); chk("R8 capture unchanged", v, last_cap[1]);

        // R9 write decode
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, v); chk("R9 flags not writable", v, 8'h0F);
        wr_reg(2'd1, 8'hA5);
        rd_reg(2'd1, v); chk("R9 cap0 not writable", v, last_cap[0]);
        wr_reg(2'd3, 8'h00);
        rd_reg(2'd0, v); chk("R9 addr3 write ignored", v, 8'h0F);
        rd_reg(2'd3, v); chk("R9 addr3 reads zero", v, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule